// File: doc/BRIEF.md
# Table-Driven Polynomial Kernel Evaluator

This block evaluates a kernel function of one variable as a piecewise polynomial. The input range is split into equal intervals of width delta, a power of two. Each interval owns one table row that holds its expansion point and the polynomial coefficients. For each sample the block picks the nearest row, takes the distance from the sample to that row's expansion point, and runs that distance through Horner's rule. One multiply-add is done in each pipeline register.

The tables sit in on-chip memories, one memory per column. They are loaded at run time through a simple write port. The same hardware therefore yields a Gaussian, a spline or any other smooth kernel, depending only on what has been written. All arithmetic is signed two's-complement fixed point with FRAC fractional bits. The block accepts a sample every cycle and returns a result a fixed number of cycles later.

Top module: `hpe_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, out_valid is 0.
- R2: The result for a sample taken with in_valid high at a clock edge appears with out_valid high exactly DEG+3 edges later. out_valid is never high without a matching input.
- R3: Samples may arrive on every cycle with no gaps, and each one produces its own result. No sample is dropped, duplicated or reordered.
- R4: The row index is round((x - B) / 2^SHIFT), rounding to nearest with ties going upward. B is the value held at column 0, row 0.
- R5: A sample whose rounded index is below 0 uses row 0.
- R6: A sample whose rounded index is above DEPTH-1 uses row DEPTH-1.
- R7: Column 0 of the selected row holds the expansion point c. The distance d = x - c is formed modulo 2^DW, so a sample equal to c yields the column-1 value.
- R8: Column k (k = 1..DEG+1) holds the coefficient of d^(k-1). The accumulator starts at column DEG+1. For j = DEG-1 down to 0 it becomes trunc_DW((d*acc) >>> FRAC) + column j+1, where the shift is arithmetic and the sum wraps at DW bits.
- R9: A write with wr_en high stores wr_data at row wr_addr of column wr_col. Later samples use the new content, so a reload changes the evaluated function.
- R10: When wr_en is low, wr_col, wr_addr and wr_data have no effect on any table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | DW | Sample, signed fixed point |
| wr_en | input | 1 | Table write strobe |
| wr_col | input | CW | Column select: 0 = centre, k = coefficient of d^(k-1) |
| wr_addr | input | AW | Row select |
| wr_data | input | DW | Value to store |
| out_valid | output | 1 | Result strobe |
| out_y | output | DW | Kernel value, signed fixed point |

## Verification
The bench goes after rounding ties on either side of a row boundary. A design that truncated there, or rounded ties downward, would read the neighbouring row and return a visibly different value. It drives samples well beyond both ends of the table. Without clamping, the index would wrap and fetch an unrelated row. It streams long gapless bursts and isolated pulses to catch a wrong stage count, a misaligned coefficient, or a valid bit out of step with its data. It also presents garbage on the write port with the strobe low, including an attempt to alter the row-0 centre that sets the index base, and it reloads the tables to confirm the function follows them.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
    // address width for a table of n entries, never below one bit
    function automatic int abits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/hpe_coef_bank.sv
module hpe_coef_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hpe_index.sv
module hpe_index #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_x,
    input  logic [DW-1:0] base,
    output logic          v_o,
    output logic [AW-1:0] idx_o,
    output logic [DW-1:0] x_o
);
    localparam int EW = DW + 2;
    localparam logic signed [EW-1:0] HALF = (SHIFT > 0) ? EW'(1 << (SHIFT - 1)) : '0;
    localparam logic signed [EW-1:0] TOP  = EW'(DEPTH - 1);
    localparam logic signed [EW-1:0] SPAN = EW'(DEPTH << SHIFT);

    typedef struct packed {
        logic          v;
        logic [AW-1:0] idx;
        logic [DW-1:0] x;
    } ix_t;

    ix_t st_d, st_q;
    logic signed [DW-1:0] xs, bs;
    logic signed [EW-1:0] diff_d, row_d;

    assign xs = in_x;
    assign bs = base;

    always_comb begin
        diff_d = EW'(xs) - EW'(bs) + HALF;
        row_d  = diff_d >>> SHIFT;
        st_d.v = in_valid;
        st_d.x = in_x;
        if (row_d < 0)        st_d.idx = '0;
        else if (row_d > TOP) st_d.idx = AW'(DEPTH - 1);
        else                  st_d.idx = AW'(row_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o   = st_q.v;
    assign idx_o = st_q.idx;
    assign x_o   = st_q.x;

    // R5: a sample below the base can only land on row 0
    a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xs < bs) |=> (idx_o == '0));

    // R6: a sample a full table span above the base lands on the last row
    a_r6_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (EW'(xs) >= EW'(bs) + SPAN)) |=> (idx_o == AW'(DEPTH - 1)));
endmodule

// File: rtl/hpe_horner_step.sv
module hpe_horner_step #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int NC   = 3,
    parameter int J    = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   v_in,
    input  logic [DW-1:0]          d_in,
    input  logic [DW-1:0]          acc_in,
    input  logic [NC-1:0][DW-1:0]  cf_in,
    output logic                   v_out,
    output logic [DW-1:0]          d_out,
    output logic [DW-1:0]          acc_out,
    output logic [NC-1:0][DW-1:0]  cf_out
);
    typedef struct packed {
        logic                  v;
        logic [DW-1:0]         d;
        logic [DW-1:0]         acc;
        logic [NC-1:0][DW-1:0] cf;
    } hs_t;

    hs_t st_d, st_q;
    logic signed [DW-1:0]   ds, as;
    logic signed [2*DW-1:0] prod_d;

    assign ds = d_in;
    assign as = acc_in;

    always_comb begin
        prod_d     = (2*DW)'(ds) * (2*DW)'(as);
        st_d.v     = v_in;
        st_d.d     = d_in;
        st_d.cf    = cf_in;
        st_d.acc   = DW'(prod_d >>> FRAC) + cf_in[J];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_out   = st_q.v;
    assign d_out   = st_q.d;
    assign acc_out = st_q.acc;
    assign cf_out  = st_q.cf;

    // R2: the valid flag advances exactly one stage per edge
    a_r2_valid_carry: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out);
endmodule

// File: rtl/hpe_top.sv
module hpe_top #(
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int DEG   = 2,
    parameter int DEPTH = 16,
    parameter int SHIFT = 4,
    localparam int NCOL = DEG + 2,
    localparam int NC   = DEG + 1,
    localparam int AW   = hpe_pkg::abits(DEPTH),
    localparam int CW   = hpe_pkg::abits(NCOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_x,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_col,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          out_valid,
    output logic [DW-1:0] out_y
);
    typedef struct packed {
        logic          v2;
        logic [DW-1:0] x2;
        logic          v3;
        logic [DW-1:0] d3;
        logic [DW-1:0] acc3;
        logic [NC-1:0][DW-1:0] cf3;
        logic [DW-1:0] base;
    } tp_t;

    tp_t st_d, st_q;

    logic          v1;
    logic [AW-1:0] idx1;
    logic [DW-1:0] x1;
    logic [DW-1:0] rdat [NCOL];

    hpe_index #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .SHIFT(SHIFT)) index_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .base(st_q.base), .v_o(v1), .idx_o(idx1), .x_o(x1)
    );

    for (genvar k = 0; k < NCOL; k++) begin : g_bank
        hpe_coef_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) bank_i (
            .clk(clk),
            .we(wr_en && (wr_col == CW'(k))),
            .waddr(wr_addr), .wdata(wr_data),
            .raddr(idx1), .rdata(rdat[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.v2   = v1;
        st_d.x2   = x1;
        st_d.v3   = st_q.v2;
        st_d.d3   = st_q.x2 - rdat[0];
        st_d.acc3 = rdat[NCOL-1];
        for (int k = 0; k < NC; k++) st_d.cf3[k] = rdat[k+1];
        if (wr_en && wr_col == '0 && wr_addr == '0) st_d.base = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic                  hv   [DEG+1];
    logic [DW-1:0]         hd   [DEG+1];
    logic [DW-1:0]         hacc [DEG+1];
    logic [NC-1:0][DW-1:0] hcf  [DEG+1];

    assign hv[0]   = st_q.v3;
    assign hd[0]   = st_q.d3;
    assign hacc[0] = st_q.acc3;
    assign hcf[0]  = st_q.cf3;

    for (genvar s = 0; s < DEG; s++) begin : g_step
        hpe_horner_step #(.DW(DW), .FRAC(FRAC), .NC(NC), .J(DEG - 1 - s)) step_i (
            .clk(clk), .rst_n(rst_n),
            .v_in(hv[s]), .d_in(hd[s]), .acc_in(hacc[s]), .cf_in(hcf[s]),
            .v_out(hv[s+1]), .d_out(hd[s+1]), .acc_out(hacc[s+1]), .cf_out(hcf[s+1])
        );
    end

    assign out_valid = hv[DEG];
    assign out_y     = hacc[DEG];

    // R3: every accepted sample enters the pipe on the next edge
    a_r3_accept_each: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> v1);
endmodule

// File: tb/hpe_top_tb_top.sv
module hpe_top_tb_top;
    localparam int DW = 16, FRAC = 8, DEG = 2, DEPTH = 16, SHIFT = 4;
    localparam int NCOL = DEG + 2, LAT = DEG + 3, AW = 4, CW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] in_x = '0, wr_data = '0, out_y;
    logic [CW-1:0] wr_col = '0;
    logic [AW-1:0] wr_addr = '0;
    logic out_valid;

    int checks = 0, errors = 0;
    int tab [NCOL][DEPTH];
    bit    qv[$];
    int    qy[$];
    string qt[$];

    always #10 clk = ~clk;

    hpe_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .wr_en(wr_en), .wr_col(wr_col), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_y(out_y)
    );

    function automatic int w16(input int v);
        return int'($signed(v[15:0]));
    endfunction

    function automatic int row_of(input int x);
        int r;
        r = (x - tab[0][0] + (1 << (SHIFT - 1))) >>> SHIFT;
        if (r < 0) r = 0;
        if (r > DEPTH - 1) r = DEPTH - 1;
        return r;
    endfunction

    function automatic int model(input int x);
        int r, d, acc;
        r = row_of(x);
        d = w16(x - tab[0][r]);
        acc = tab[DEG+1][r];
        for (int j = DEG - 1; j >= 0; j--)
            acc = w16(w16((d * acc) >>> FRAC) + tab[j+1][r]);
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: compare the result due now, then drive the next sample
    task automatic step(input bit v, input int x, input string tag);
        @(negedge clk);
        if (qv.size() == LAT) begin
            bit ev; int ey; string et;
            ev = qv.pop_front(); ey = qy.pop_front(); et = qt.pop_front();
            check(out_valid == ev, {et, " R2 valid"}, int'(out_valid), int'(ev));
            if (ev) check(int'($signed(out_y)) == ey, et, int'($signed(out_y)), ey);
        end
        in_valid = v;
        in_x = DW'(x);
        qv.push_back(v);
        qy.push_back(v ? model(x) : 0);
        qt.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, "idle");
    endtask

    // R9: column 0 = centre, column k = coefficient of d^(k-1)
    task automatic write(input int col, input int addr, input int data, input bit en);
        wr_en = en; wr_col = CW'(col); wr_addr = AW'(addr); wr_data = DW'(data);
        step(1'b0, 0, "idle");
        wr_en = 1'b0;
        if (en) tab[col][addr] = w16(data);
    endtask

    task automatic load(input int base, input int spread);
        for (int r = 0; r < DEPTH; r++) begin
            write(0, r, base + (r << SHIFT), 1'b1);
            for (int k = 1; k < NCOL; k++)
                write(k, r, int'($urandom_range(2 * spread)) - spread, 1'b1);
        end
        idle(LAT);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int b;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);
        for (int i = 0; i < LAT; i++) begin qv.push_back(1'b0); qy.push_back(0); qt.push_back("idle"); end

        load(-512, 600);
        b = tab[0][0];
        // R4: rounding ties around row boundaries
        step(1'b1, b + 7, "R4 below tie");
        step(1'b1, b + 8, "R4 tie rounds up");
        step(1'b1, b + 40, "R4 tie row 3");
        step(1'b1, b + 39, "R4 below tie row 3");
        // R5 / R6: clamping at both ends
        step(1'b1, b - 9, "R5 just below");
        step(1'b1, b - 3000, "R5 far below");
        step(1'b1, b + (DEPTH << SHIFT) + 100, "R6 far above");
        step(1'b1, 32767, "R6 max input");
        // R7: sample at a centre returns column 1
        step(1'b1, b + (5 << SHIFT), "R7 at centre");
        idle(2);
        // R2: isolated pulses
        step(1'b1, b + 77, "R2 pulse");
        idle(LAT + 1);
        step(1'b1, b + 130, "R2 pulse 2");
        idle(3);
        // R3 / R8: gapless random burst
        for (int i = 0; i < 400; i++)
            step(1'b1, b - 64 + int'($urandom_range((DEPTH << SHIFT) + 128)), "R3 R8 burst");
        for (int i = 0; i < 200; i++)
            step($urandom_range(1) == 1, int'($urandom_range(65535)) - 32768, "R8 random gaps");
        idle(LAT);
        // R10: write strobe low, including the centre that sets the base
        write(0, 0, 1000, 1'b0);
        write(2, 3, 12345, 1'b0);
        write(3, 7, -999, 1'b0);
        step(1'b1, b + 8, "R10 base kept");
        step(1'b1, b + (3 << SHIFT) + 2, "R10 row 3 kept");
        step(1'b1, b + (7 << SHIFT) - 5, "R10 row 7 kept");
        idle(LAT);
        // R9: reload with a different kernel
        load(200, 300);
        b = tab[0][0];
        for (int i = 0; i < 300; i++)
            step(1'b1, b - 40 + int'($urandom_range((DEPTH << SHIFT) + 80)), "R9 reloaded");
        step(1'b1, b + 8, "R9 R4 tie after reload");
        idle(LAT + 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule